// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This unit compares two IEEE-754 operands, either both single precision or both double precision, against one of sixteen compare predicates. It then writes the outcome into a floating-point condition flag, which later branch or conditional-move logic reads. It also reports whether the compare raised the invalid-operation exception. An issue stage pulses `start` for one cycle and presents the format bit, a 4-bit predicate code and both operand bit patterns. The unit captures them on that edge. On the following edge it commits the condition flag and the invalid flag and pulses `done` for one cycle. Both flags keep their values until the next compare commits.

The predicate code is split into fields. Bits [2:1] select the base relation: 0 never, 1 equal, 2 less-than, 3 less-or-equal. Bit 0 adds "or unordered" to that relation. Bit 3 chooses the signaling family, in which any NaN operand raises invalid. With bit 3 clear, the quiet family raises invalid only for a signaling NaN.

Top module: `fcmp_cond_unit`

## Requirements
- R1: While reset is held and after its release with no compare issued, `condFlag`, `invalidFlag` and `done` are all 0.
- R2: A `start` sampled at one rising edge produces `done` = 1 for exactly one cycle, following the next rising edge. A cycle with no compare in flight has `done` = 0.
- R3: The result is `(code[0] AND unordered) OR rel`, where rel is chosen by code[2:1] (0 none, 1 equal, 2 less, 3 less-or-equal) and is always false for unordered operands. Operand A is the left-hand side.
- R4: Codes 0 and 8 (code[2:0] = 0) always clear `condFlag`. Code 8 still reports invalid on a NaN.
- R5: Positive zero and negative zero compare equal, and neither is less than the other.
- R6: Non-NaN values are ordered by sign and magnitude: negatives below positives, with larger magnitude lower among negatives. Infinities and subnormals are ordered consistently with this.
- R7: With code[3] = 0, `invalidFlag` is set only when an operand is a signaling NaN. A signaling NaN has an all-ones exponent, a nonzero fraction and fraction MSB = 0. A quiet NaN has fraction MSB = 1.
- R8: With code[3] = 1, `invalidFlag` is set when either operand is any NaN.
- R9: With `isDouble` = 0 the operands are bits [31:0] of `opA`/`opB` in single format, and bits [63:32] have no effect. With `isDouble` = 1 all 64 bits form a double.
- R10: When no compare commits, `condFlag` and `invalidFlag` hold their values whatever the inputs do. Operand inputs changed after the `start` cycle do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle compare request; inputs captured on this edge |
| isDouble | input | 1 | 1 = double format, 0 = single format in low 32 bits |
| cond | input | 4 | Predicate code: [3] signaling family, [2:1] relation, [0] or-unordered |
| opA | input | 64 | Left-hand operand bit pattern |
| opB | input | 64 | Right-hand operand bit pattern |
| condFlag | output | 1 | Floating-point condition flag, updated when a compare commits |
| invalidFlag | output | 1 | Invalid-operation report of the last committed compare |
| done | output | 1 | One-cycle pulse when a result has committed |

## Verification
Several properties are checked by assertions on every cycle. These are the start-to-done latency, the flags holding between commits, the never-true predicates, the forced result for unordered operands with code[0] set, and invalid on any NaN in the signaling family. The sign-magnitude ordering, the treatment of the two zeros, the distinction between quiet and signaling NaNs and the masking of the upper half in single format depend on operand values. Only the bench's sweep shows those. The sweep covers every predicate code over every pair from a set of special and ordinary values in both formats, and computes each expected result from real-number comparisons.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic commit;
  } cmpStrobe_t;

  // base relation chosen by code[2:1]
  typedef enum logic [1:0] {
    REL_NONE = 2'd0,
    REL_EQ   = 2'd1,
    REL_LT   = 2'd2,
    REL_LE   = 2'd3
  } relSel_e;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int MAG_W  = 63
) (
  input  logic [EXP_W+FRAC_W:0] value,
  output logic                  isNan,
  output logic                  isSignaling,
  output logic                  isZero,
  output logic                  signBit,
  output logic [MAG_W-1:0]      magnitude
);
  localparam int TOTAL_W = EXP_W + FRAC_W + 1;

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;

  assign expField    = value[TOTAL_W-2:FRAC_W];
  assign fracField   = value[FRAC_W-1:0];
  assign isNan       = (&expField) & (|fracField);
  assign isSignaling = isNan & ~fracField[FRAC_W-1];
  assign isZero      = ~|value[TOTAL_W-2:0];
  assign signBit     = value[TOTAL_W-1];

  always_comb begin
    magnitude = '0;
    magnitude[TOTAL_W-2:0] = value[TOTAL_W-2:0];
  end
endmodule

// File: rtl/fcmp_control.sv
module fcmp_control
  import fcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output cmpStrobe_t strobe,
  output logic       done
);
  logic pendingReg;
  logic doneReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendingReg <= 1'b0;
      doneReg    <= 1'b0;
    end else begin
      pendingReg <= start;
      doneReg    <= pendingReg;
    end
  end

  assign strobe.capture = start;
  assign strobe.commit  = pendingReg;
  assign done           = doneReg;

  // R2: a request is answered two edges later
  assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ##1 done);

  // R2: no done without a request two edges earlier
  assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start ##1 !start) |=> !done);
endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int SGL_EXP_W  = 8,
  parameter int SGL_FRAC_W = 23,
  parameter int DBL_EXP_W  = 11,
  parameter int DBL_FRAC_W = 52,
  parameter int COND_W     = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  cmpStrobe_t                           strobe,
  input  logic                                 isDouble,
  input  logic [COND_W-1:0]                    cond,
  input  logic [DBL_EXP_W+DBL_FRAC_W:0]        opA,
  input  logic [DBL_EXP_W+DBL_FRAC_W:0]        opB,
  output logic                                 condFlag,
  output logic                                 invalidFlag
);
  localparam int DBL_W = DBL_EXP_W + DBL_FRAC_W + 1;
  localparam int SGL_W = SGL_EXP_W + SGL_FRAC_W + 1;
  localparam int MAG_W = DBL_W - 1;
  localparam int NUM_OPS = 2;

  logic [DBL_W-1:0]  opReg [NUM_OPS];
  logic [COND_W-1:0] condReg;
  logic              dblReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opReg[0] <= '0;
      opReg[1] <= '0;
      condReg  <= '0;
      dblReg   <= 1'b0;
    end else if (strobe.capture) begin
      opReg[0] <= opA;
      opReg[1] <= opB;
      condReg  <= cond;
      dblReg   <= isDouble;
    end
  end

  logic             nanOp  [NUM_OPS];
  logic             snanOp [NUM_OPS];
  logic             zeroOp [NUM_OPS];
  logic             signOp [NUM_OPS];
  logic [MAG_W-1:0] magOp  [NUM_OPS];

  for (genvar g = 0; g < NUM_OPS; g++) begin : gOperand
    logic sNan, sSnan, sZero, sSign, dNan, dSnan, dZero, dSign;
    logic [MAG_W-1:0] sMag, dMag;

    fcmp_classify #(.EXP_W(SGL_EXP_W), .FRAC_W(SGL_FRAC_W), .MAG_W(MAG_W)) uSingle (
      .value(opReg[g][SGL_W-1:0]), .isNan(sNan), .isSignaling(sSnan),
      .isZero(sZero), .signBit(sSign), .magnitude(sMag));

    fcmp_classify #(.EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W), .MAG_W(MAG_W)) uDouble (
      .value(opReg[g]), .isNan(dNan), .isSignaling(dSnan),
      .isZero(dZero), .signBit(dSign), .magnitude(dMag));

    assign nanOp[g]  = dblReg ? dNan  : sNan;
    assign snanOp[g] = dblReg ? dSnan : sSnan;
    assign zeroOp[g] = dblReg ? dZero : sZero;
    assign signOp[g] = dblReg ? dSign : sSign;
    assign magOp[g]  = dblReg ? dMag  : sMag;
  end

  logic unordered, bothZero, sameSign, magLess, magGreater, magEqual;
  logic relEq, relLt, relLe, relVal, predicate, invalidNext;

  assign unordered  = nanOp[0] | nanOp[1];
  assign bothZero   = zeroOp[0] & zeroOp[1];
  assign sameSign   = signOp[0] == signOp[1];
  assign magLess    = magOp[0] < magOp[1];
  assign magGreater = magOp[1] < magOp[0];
  assign magEqual   = magOp[0] == magOp[1];

  assign relEq = ~unordered & (bothZero | (sameSign & magEqual));
  assign relLt = ~unordered & ~bothZero &
                 ((signOp[0] & ~signOp[1]) |
                  (sameSign & (signOp[0] ? magGreater : magLess)));
  assign relLe = relEq | relLt;

  always_comb begin
    unique case (relSel_e'(condReg[2:1]))
      REL_EQ:  relVal = relEq;
      REL_LT:  relVal = relLt;
      REL_LE:  relVal = relLe;
      default: relVal = 1'b0;
    endcase
  end

  assign predicate   = (condReg[0] & unordered) | relVal;
  assign invalidNext = condReg[COND_W-1] ? unordered : (snanOp[0] | snanOp[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      condFlag    <= 1'b0;
      invalidFlag <= 1'b0;
    end else if (strobe.commit) begin
      condFlag    <= predicate;
      invalidFlag <= invalidNext;
    end
  end

  // R10: flags only move on a commit
  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.commit |=> ($stable(condFlag) && $stable(invalidFlag)));

  // R4: never-true predicates clear the flag
  assert_never_pred_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && condReg[2:0] == 3'b000) |=> !condFlag);

  // R3: or-unordered predicates are true on NaN operands
  assert_unordered_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && condReg[0] && unordered) |=> condFlag);

  // R8: signaling family reports invalid on any NaN
  assert_signaling_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && condReg[COND_W-1] && unordered) |=> invalidFlag);
endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit
  import fcmp_pkg::*;
#(
  parameter int SGL_EXP_W  = 8,
  parameter int SGL_FRAC_W = 23,
  parameter int DBL_EXP_W  = 11,
  parameter int DBL_FRAC_W = 52,
  parameter int COND_W     = 4,
  localparam int DBL_W     = DBL_EXP_W + DBL_FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              isDouble,
  input  logic [COND_W-1:0] cond,
  input  logic [DBL_W-1:0]  opA,
  input  logic [DBL_W-1:0]  opB,
  output logic              condFlag,
  output logic              invalidFlag,
  output logic              done
);
  cmpStrobe_t strobe;

  fcmp_control uControl (
    .clk(clk), .rst_n(rst_n), .start(start), .strobe(strobe), .done(done));

  fcmp_datapath #(
    .SGL_EXP_W(SGL_EXP_W), .SGL_FRAC_W(SGL_FRAC_W),
    .DBL_EXP_W(DBL_EXP_W), .DBL_FRAC_W(DBL_FRAC_W), .COND_W(COND_W)
  ) uDatapath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .isDouble(isDouble),
    .cond(cond), .opA(opA), .opB(opB),
    .condFlag(condFlag), .invalidFlag(invalidFlag));
endmodule

// File: tb/fcmp_cond_unit_test.sv
module fcmp_cond_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        isDouble = 1'b0;
  logic [3:0]  cond = '0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        condFlag, invalidFlag, done;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fcmp_cond_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .isDouble(isDouble), .cond(cond),
    .opA(opA), .opB(opB), .condFlag(condFlag), .invalidFlag(invalidFlag), .done(done));

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] dval(input int i);
    case (i)
      0: return 64'h0000000000000000;   1: return 64'h8000000000000000;
      2: return 64'h3FF0000000000000;   3: return 64'hBFF0000000000000;
      4: return 64'h4000000000000000;   5: return 64'hC000000000000000;
      6: return 64'h7FF0000000000000;   7: return 64'hFFF0000000000000;
      8: return 64'h7FF8000000000000;   9: return 64'h7FF0000000000001;
      10: return 64'hFFF8000000000000;  11: return 64'h0000000000000001;
      12: return 64'h8000000000000001;  13: return 64'h7FEFFFFFFFFFFFFF;
      14: return 64'h3FF8000000000000;  default: return 64'hBFE0000000000000;
    endcase
  endfunction

  function automatic logic [31:0] sval(input int i);
    case (i)
      0: return 32'h00000000;   1: return 32'h80000000;
      2: return 32'h3F800000;   3: return 32'hBF800000;
      4: return 32'h40000000;   5: return 32'hC0000000;
      6: return 32'h7F800000;   7: return 32'hFF800000;
      8: return 32'h7FC00000;   9: return 32'h7F800001;
      10: return 32'hFFC00000;  11: return 32'h00000001;
      12: return 32'h80000001;  13: return 32'h7F7FFFFF;
      14: return 32'h3FC00000;  default: return 32'hBF000000;
    endcase
  endfunction

  // exact single-to-double widening of a bit pattern
  function automatic logic [63:0] widen(input logic [31:0] s);
    logic [7:0] e;
    logic [23:0] f;
    int ee;
    e = s[30:23];
    f = {1'b0, s[22:0]};
    if (e == 8'hFF) return {s[31], 11'h7FF, s[22:0], 29'b0};
    if (e == 8'h00 && f == 0) return {s[31], 63'b0};
    if (e == 8'h00) begin
      ee = -126;
      while (f[23] == 1'b0) begin f = f << 1; ee--; end
    end else begin
      ee = int'(e) - 127;
      f[23] = 1'b1;
    end
    return {s[31], 11'(ee + 1023), f[22:0], 29'b0};
  endfunction

  function automatic bit isNanBits(input logic [63:0] d);
    return (d[62:52] == 11'h7FF) && (d[51:0] != 0);
  endfunction

  task automatic runCompare(input logic dbl, input logic [3:0] c,
                            input logic [63:0] a, input logic [63:0] b);
    logic [63:0] da, db;
    real ra, rb;
    bit unord, snan, rel, expFlag, expInv;
    string tagF, tagI;
    @(negedge clk);
    isDouble = dbl; cond = c; opA = a; opB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; opA = ~a; opB = ~b; cond = ~c; isDouble = ~dbl;  // R10: late changes ignored
    @(negedge clk);
    da = dbl ? a : widen(a[31:0]);
    db = dbl ? b : widen(b[31:0]);
    unord = isNanBits(da) || isNanBits(db);
    snan = (isNanBits(da) && !da[51]) || (isNanBits(db) && !db[51]);
    ra = $bitstoreal(da);
    rb = $bitstoreal(db);
    case (c[2:1])
      2'd1: rel = !unord && (ra == rb);
      2'd2: rel = !unord && (ra < rb);
      2'd3: rel = !unord && (ra <= rb);
      default: rel = 1'b0;
    endcase
    expFlag = (c[0] && unord) || rel;
    expInv = c[3] ? unord : snan;
    if (c[2:0] == 3'b000) tagF = "R4";
    else if (da[62:0] == 0 && db[62:0] == 0) tagF = "R5";
    else if (!dbl) tagF = "R9";
    else if (da[63] || db[63]) tagF = "R6";
    else tagF = "R3";
    tagI = c[3] ? "R8" : "R7";
    check("R2", "done", done, 1'b1);
    check(tagF, $sformatf("condFlag dbl=%0b code=%0d a=%h b=%h", dbl, c, a, b), condFlag, expFlag);
    check(tagI, $sformatf("invalidFlag dbl=%0b code=%0d a=%h b=%h", dbl, c, a, b), invalidFlag, expInv);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "condFlag in reset", condFlag, 1'b0);
    check("R1", "invalidFlag in reset", invalidFlag, 1'b0);
    check("R1", "done in reset", done, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "condFlag after reset", condFlag, 1'b0);
    check("R1", "done after reset", done, 1'b0);

    // R10: a true result then idle cycles with busy inputs
    runCompare(1'b1, 4'd2, dval(2), dval(2));
    @(negedge clk);
    check("R2", "done falls", done, 1'b0);
    opA = dval(8); opB = dval(9); cond = 4'd9; isDouble = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", "condFlag held", condFlag, 1'b1);
    check("R10", "invalidFlag held", invalidFlag, 1'b0);
    check("R2", "done idle", done, 1'b0);

    for (int fmt = 0; fmt < 2; fmt++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          for (int c = 0; c < 16; c++) begin
            if (fmt == 1)
              runCompare(1'b1, 4'(c), dval(i), dval(j));
            else
              runCompare(1'b0, 4'(c),
                         {32'(32'h5A5A0000 + i * 32'h01010101), sval(i)},
                         {32'(32'hC3C30000 + j * 32'h00110011 + c), sval(j)});
          end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule